// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table kept in main memory. The logical address has three fields. The top 12 bits index the outer table. The next 10 bits index the inner table chosen by the outer entry. The low 10 bits are the byte offset within a 1 KB page. The base address of the outer table comes from a per-process base register, which is a plain input to the block.

A request arrives on a valid/ready stream. The walker then issues two dependent reads on a simple memory port. That port uses a valid/ready request channel and a response channel that has a valid pulse only and may arrive any number of cycles later. Each entry read is checked for its valid bit. The walker returns the result on a second valid/ready stream: either the physical address, or a fault that names the level that failed.

Only one walk is in progress at a time. Back-pressure rules on the three channels:
- Request stream: no new request is taken while a walk or an unconsumed result is pending.
- Memory request channel: the memory may stall it indefinitely, and the address stays stable while it does.
- Result stream: the result stays on the outputs until the consumer takes it.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. It stays low from the accepting edge until the edge on which the result is taken. A request is accepted on an edge where both `req_valid_o`-side signals `req_valid_i` and `req_ready_o` are high.
- R2: The base register and the logical address are captured on the accepting edge. Changes on `ptbr_i` or `req_vaddr_i` during a walk have no effect on the walk.
- R3: The first memory read goes to base + 4 × vaddr[31:20].
- R4: The second memory read goes to {outer[31:12], 12'b0} + 4 × vaddr[19:10], where outer is the entry returned by the first read.
- R5: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address stay unchanged. A `mem_rsp_valid_i` pulse is ignored unless a request has been accepted and its response is still pending.
- R6: Bit 0 of every entry is the valid bit. If the outer entry has bit 0 at 0, the walk ends with a fault at level 0, `rsp_fault_lvl_o` = 0, and no inner read is issued.
- R7: If the inner entry has bit 0 at 0, the walk ends with a fault at level 1, `rsp_fault_lvl_o` = 1. On any fault, `rsp_paddr_o` is 0.
- R8: If the walk succeeds, `rsp_fault_o` = 0 and `rsp_paddr_o` = {inner[31:10], vaddr[9:0]}.
- R9: The result stays valid and stable until `rsp_ready_i` is high. On the cycle after it is taken, the walker is idle again.
- R10: After reset, the walker is idle: `req_ready_o` = 1, and `mem_req_valid_o` = 0 and `rsp_valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_i | input | 32 | Outer table base for the current process |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Logical address to translate |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid (one cycle) |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl_o | output | 1 | Failing level: 0 outer, 1 inner |

## Verification
The walks use several kinds of address:
- The all-zero address shows that zero indices and a zero offset are handled.
- The all-ones address drives the widest outer and inner indices. It catches a wrong split or a truncated index in the address sums.
- A mixed address with scattered bits catches swapped index fields.

Outer entries with junk in their low bits show that only the upper bits form the inner base. An invalid outer entry and an invalid inner entry show the two fault levels apart. Varying memory latency and held-off ready signals on both the memory and result channels show that each stage waits on its handshake and not on a fixed count.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned OFF_W    = 10;
  localparam int unsigned L1_W     = 12;
  localparam int unsigned L2_W     = 10;
  localparam int unsigned PTE_SH   = 2;
  localparam int unsigned VLD_BIT  = 0;
  localparam int unsigned TBL_ALGN = L2_W + PTE_SH;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUT,
    ST_WT_OUT,
    ST_RD_IN,
    ST_WT_IN,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PTE_SH = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PAD_W = AW - IDX_W - PTE_SH;

  logic [AW-1:0] scaled;

  assign scaled = {{PAD_W{1'b0}}, idx_i, {PTE_SH{1'b0}}};
  assign addr_o = base_i + scaled;
endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptbr_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_vaddr_i,
  output logic [AW-1:0] vaddr_q_o,
  output logic [AW-1:0] ptbr_q_o,
  output logic [AW-1:0] inner_base_o,
  input  logic [AW-1:0] outer_addr_i,
  input  logic [AW-1:0] inner_addr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_paddr_o,
  output logic          rsp_fault_o,
  output logic          rsp_fault_lvl_o
);
  walk_st_e      state;
  logic [AW-1:0] vaddr_q;
  logic [AW-1:0] ptbr_q;
  logic [AW-1:0] inner_base_q;
  logic [AW-1:0] paddr_q;
  logic          lvl_q;
  logic          pte_ok;
  logic          unused_pte_bits;

  assign pte_ok          = mem_rsp_data_i[VLD_BIT];
  assign unused_pte_bits = ^mem_rsp_data_i[OFF_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      vaddr_q      <= '0;
      ptbr_q       <= '0;
      inner_base_q <= '0;
      paddr_q      <= '0;
      lvl_q        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid_i) begin
            vaddr_q <= req_vaddr_i;
            ptbr_q  <= ptbr_i;
            state   <= ST_RD_OUT;
          end
        end
        ST_RD_OUT: begin
          if (mem_req_ready_i) state <= ST_WT_OUT;
        end
        ST_WT_OUT: begin
          if (mem_rsp_valid_i) begin
            if (!pte_ok) begin
              lvl_q <= 1'b0;
              state <= ST_FAULT;
            end else begin
              inner_base_q <= {mem_rsp_data_i[AW-1:TBL_ALGN], {TBL_ALGN{1'b0}}};
              state        <= ST_RD_IN;
            end
          end
        end
        ST_RD_IN: begin
          if (mem_req_ready_i) state <= ST_WT_IN;
        end
        ST_WT_IN: begin
          if (mem_rsp_valid_i) begin
            if (!pte_ok) begin
              lvl_q <= 1'b1;
              state <= ST_FAULT;
            end else begin
              paddr_q <= {mem_rsp_data_i[AW-1:OFF_W], vaddr_q[OFF_W-1:0]};
              state   <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (rsp_ready_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign mem_req_valid_o = (state == ST_RD_OUT) || (state == ST_RD_IN);
  assign mem_req_addr_o  = (state == ST_RD_IN) ? inner_addr_i : outer_addr_i;
  assign rsp_valid_o     = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault_o     = (state == ST_FAULT);
  assign rsp_fault_lvl_o = (state == ST_FAULT) ? lvl_q : 1'b0;
  assign rsp_paddr_o     = (state == ST_DONE) ? paddr_q : '0;
  assign vaddr_q_o       = vaddr_q;
  assign ptbr_q_o        = ptbr_q;
  assign inner_base_o    = inner_base_q;

  // R1: only one of the three channels is active at a time
  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready_o, mem_req_valid_o, rsp_valid_o}));

  // R5: a stalled memory request keeps its address
  a_r5_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R7: a fault never carries a physical address
  a_r7_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0));

  // R9: a result not taken stays put
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)
       && $stable(rsp_fault_lvl_o)));

  // R9: a taken result returns the walker to idle
  a_r9_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_ready_i) |=> req_ready_o);

  // R1: an accepted request starts a memory read next cycle
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (mem_req_valid_o && !req_ready_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ptbr_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_vaddr_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [31:0]   rsp_paddr_o,
  output logic          rsp_fault_o,
  output logic          rsp_fault_lvl_o
);
  localparam int unsigned L1_LO = OFF_W + L2_W;

  logic [AW-1:0] vaddr_q;
  logic [AW-1:0] ptbr_q;
  logic [AW-1:0] inner_base;
  logic [AW-1:0] outer_addr;
  logic [AW-1:0] inner_addr;

  pt_entry_addr #(.AW(AW), .IDX_W(L1_W), .PTE_SH(PTE_SH)) i_outer_addr (
    .base_i (ptbr_q),
    .idx_i  (vaddr_q[AW-1:L1_LO]),
    .addr_o (outer_addr)
  );

  pt_entry_addr #(.AW(AW), .IDX_W(L2_W), .PTE_SH(PTE_SH)) i_inner_addr (
    .base_i (inner_base),
    .idx_i  (vaddr_q[L1_LO-1:OFF_W]),
    .addr_o (inner_addr)
  );

  pt_walker_ctrl i_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .ptbr_i          (ptbr_i),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_vaddr_i     (req_vaddr_i),
    .vaddr_q_o       (vaddr_q),
    .ptbr_q_o        (ptbr_q),
    .inner_base_o    (inner_base),
    .outer_addr_i    (outer_addr),
    .inner_addr_i    (inner_addr),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_fault_lvl_o (rsp_fault_lvl_o)
  );
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbr_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic        rsp_fault_lvl_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (.*);

  typedef struct packed {
    logic [31:0] ptbr;
    logic [31:0] va;
    logic [31:0] opte;
    logic [31:0] ipte;
    logic [3:0]  lat;
    logic [3:0]  hold;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0010_0000, 32'h0000_0000, 32'h0020_0001, 32'h1234_5401, 4'd0, 4'd0},
    '{32'h0010_0000, 32'hFFFF_FFFF, 32'hABCD_E003, 32'h8000_0001, 4'd3, 4'd1},
    '{32'h0040_0000, 32'h1234_5678, 32'h0020_0000, 32'h1111_1401, 4'd1, 4'd0},
    '{32'h0000_4000, 32'h8765_4321, 32'h0033_3FFF, 32'h5555_5400, 4'd2, 4'd2},
    '{32'h0000_4000, 32'h1234_5678, 32'h0F0F_0001, 32'h0ABC_D7FF, 4'd2, 4'd3},
    '{32'hFFFF_0000, 32'h0030_0C05, 32'h7777_7001, 32'h0000_0401, 4'd5, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // serve one memory read: stall a cycle, inject a stray response, accept, respond
  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                       input int lat, input string tag);
    chk(mem_req_valid_o == 1'b1, {tag, " req valid"}, 32'(mem_req_valid_o), 32'd1);
    chk(mem_req_addr_o == exp_addr, tag, mem_req_addr_o, exp_addr);
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = 32'h0;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    chk(mem_req_valid_o == 1'b1, "R5 stall keeps req", 32'(mem_req_valid_o), 32'd1);
    chk(mem_req_addr_o == exp_addr, "R5 stall keeps addr", mem_req_addr_o, exp_addr);
    mem_req_ready_i = 1'b1;
    @(negedge clk);
    mem_req_ready_i = 1'b0;
    for (int k = 0; k < lat; k++) begin
      chk(mem_req_valid_o == 1'b0 && req_ready_o == 1'b0, "R1 waiting",
          {30'd0, mem_req_valid_o, req_ready_o}, 32'd0);
      @(negedge clk);
    end
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = data;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = 32'h0;
  endtask

  task automatic walk(input vec_t v);
    logic [31:0] oaddr, iaddr, epa;
    bit          efault, elvl;
    oaddr  = v.ptbr + {18'd0, v.va[31:20], 2'b00};
    iaddr  = {v.opte[31:12], 12'h000} + {20'd0, v.va[19:10], 2'b00};
    efault = !v.opte[0] || !v.ipte[0];
    elvl   = v.opte[0];
    epa    = efault ? 32'h0 : {v.ipte[31:10], v.va[9:0]};

    chk(req_ready_o == 1'b1, "R1 ready idle", 32'(req_ready_o), 32'd1);
    ptbr_i      = v.ptbr;
    req_vaddr_i = v.va;
    req_valid_i = 1'b1;
    @(negedge clk);
    // R2: disturb the inputs after acceptance
    ptbr_i      = 32'hDEAD_0000;
    req_vaddr_i = ~v.va;
    chk(req_ready_o == 1'b0, "R1 ready low in walk", 32'(req_ready_o), 32'd0);
    serve(oaddr, v.opte, int'(v.lat), "R3 R2 outer addr");
    if (v.opte[0]) serve(iaddr, v.ipte, int'(v.lat), "R4 inner addr");
    else chk(mem_req_valid_o == 1'b0, "R6 no inner read", 32'(mem_req_valid_o), 32'd0);
    req_valid_i = 1'b1;
    for (int k = 0; k <= int'(v.hold); k++) begin
      chk(rsp_valid_o == 1'b1, "R9 rsp valid", 32'(rsp_valid_o), 32'd1);
      chk(rsp_fault_o == efault, efault ? "R6 R7 fault" : "R8 no fault",
          32'(rsp_fault_o), 32'(efault));
      if (efault)
        chk(rsp_fault_lvl_o == elvl, elvl ? "R7 level" : "R6 level",
            32'(rsp_fault_lvl_o), 32'(elvl));
      chk(rsp_paddr_o == epa, efault ? "R7 paddr zero" : "R8 paddr", rsp_paddr_o, epa);
      chk(req_ready_o == 1'b0, "R1 busy while rsp held", 32'(req_ready_o), 32'd0);
      if (k == int'(v.hold)) rsp_ready_i = 1'b1;
      @(negedge clk);
    end
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b0 && req_ready_o == 1'b1, "R9 idle after take",
        {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R10 reset ready", 32'(req_ready_o), 32'd1);
    chk(mem_req_valid_o == 1'b0, "R10 reset mem req", 32'(mem_req_valid_o), 32'd0);
    chk(rsp_valid_o == 1'b0, "R10 reset rsp", 32'(rsp_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) walk(VECS[i]);

    // R5: stray response while idle is ignored
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = 32'hFFFF_FFFF;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    chk(req_ready_o == 1'b1 && rsp_valid_o == 1'b0 && mem_req_valid_o == 1'b0,
        "R5 idle stray rsp", {29'd0, req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'd4);

    // R10: reset in the middle of a walk
    ptbr_i = 32'h0000_8000;
    req_vaddr_i = 32'h0010_0000;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(mem_req_valid_o == 1'b1, "R1 walk started", 32'(mem_req_valid_o), 32'd1);
    chk(mem_req_addr_o == 32'h0000_8004, "R3 outer addr", mem_req_addr_o, 32'h0000_8004);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready_o == 1'b1 && mem_req_valid_o == 1'b0 && rsp_valid_o == 1'b0,
        "R10 mid-walk reset", {29'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 32'd4);
    @(negedge clk);

    // one more walk after reset
    walk(VECS[4]);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule